// File: doc/BRIEF.md
# Key Code Queue and Sensor Image Store

This block is the storage stage behind a keyboard scanner. It keeps one eight-row by eight-bit array and gives it two roles. In key mode and in strobed-input mode the array is a first-in, first-out queue. Each debounced key code, or each byte latched on a strobe, joins the tail. The CPU takes entries from the head, oldest first. In sensor mode the same array is an image of a switch matrix: each row location holds the last return-line byte captured while that scan row was active. The CPU reads any row by address.

The scanner, the debounce logic and the bus decoder sit outside this block. They hand it single-cycle request pulses. The block reports:
- the number of queued entries;
- a full flag;
- a sticky overrun flag for a key lost to a full queue;
- a sticky error flag that freezes the queue;
- one interrupt line.

In queue modes the interrupt line tracks queue occupancy. In sensor mode it is a sticky change alarm.

Top module: `key_store_top`

## Requirements
- R1: Reset leaves count at 0, full, overrun, errFlag and irq all at 0. All rows read as 0x00.
- R2: In key mode (mode = 0) each cycle with keyValid high appends keyCode to the queue. rdData always shows the oldest queued byte. A cycle with rdEn high removes that byte. Push and pop in the same cycle leave count unchanged. Bytes come out in the order they went in, up to 8 entries.
- R3: A push arriving when 8 entries are held, with no pop in the same cycle, is discarded. It sets overrun. Overrun stays set until clrStatus is pulsed.
- R4: In a queue mode, irq is 1 in the cycle after any cycle in which count is non-zero and no read occurs. irq is 0 in the cycle after a read of a non-empty queue. irq is back at 1 one cycle later if entries remain.
- R5: In strobed mode (mode = 1), each high-to-low transition of strobeN pushes retLines exactly once, however long strobeN stays low. keyValid is ignored in this mode.
- R6: In sensor mode (mode = 2), a cycle with rowValid high stores retLines into row scanRow without debounce. rdData shows row rdAddr. rdEn does not remove anything.
- R7: In sensor mode, a row write whose data differs from the stored row sets irq. A write of equal data does not set it. irq then stays set until clrSensorIrq is pulsed, and a change in the same cycle wins over the clear.
- R8: errSet sets errFlag. While errFlag is set, pushes are ignored, but reads still pop. clrStatus clears errFlag.
- R9: full is 1 exactly when count equals 8.
- R10: A cycle in which mode differs from its value in the previous cycle empties the queue. It also clears overrun, errFlag and irq. Stored row data is kept.
- R11: A read of an empty queue has no effect: count stays 0 and irq stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 key, 1 strobed, 2 sensor, 3 behaves as key |
| keyValid | input | 1 | Debounced key code present (key mode) |
| keyCode | input | 8 | Key code with shift and control bits |
| strobeN | input | 1 | Active-low strobe, falling edge pushes (strobed mode) |
| retLines | input | 8 | Return-line byte |
| rowValid | input | 1 | Store retLines in row scanRow (sensor mode) |
| scanRow | input | 3 | Row being scanned |
| rdEn | input | 1 | CPU read: pops in queue modes |
| rdAddr | input | 3 | Row to read in sensor mode |
| errSet | input | 1 | Simultaneous-key error from the scanner |
| clrStatus | input | 1 | Clears overrun and errFlag |
| clrSensorIrq | input | 1 | Clears the sensor change alarm |
| rdData | output | 8 | Queue head or addressed sensor row |
| count | output | 4 | Queued entries, 0 to 8 |
| full | output | 1 | Queue holds 8 entries |
| overrun | output | 1 | Sticky: a push was lost |
| errFlag | output | 1 | Sticky: queue frozen by error |
| irq | output | 1 | Interrupt request |

## Verification
The queue is driven through three kinds of traffic:
- Interleaved pushes and pops, including a simultaneous push and pop. This tells a correct pointer update from one that double-counts.
- A run that fills all eight slots and then offers a ninth byte. This separates discard-on-full from overwrite-on-full.
- A full drain. Its output order exposes any wrap error in the pointers.

A held-low strobe tells edge detection from level detection. In sensor mode, a rewrite with identical data tells change detection from plain write detection.

// File: rtl/key_store_pkg.sv
package key_store_pkg;

  localparam int ROW_BITS  = 3;
  localparam int DATA_BITS = 8;

  typedef enum logic [1:0] {
    MODE_KEYS   = 2'd0,
    MODE_STROBE = 2'd1,
    MODE_SENSOR = 2'd2,
    MODE_SPARE  = 2'd3
  } storeMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                memWe;
    logic [ROW_BITS-1:0] wrRow;
    logic                selRet;
    logic [ROW_BITS-1:0] rdRow;
  } ctrlStrobes_t;

endpackage

// File: rtl/key_store_dp.sv
module key_store_dp
  import key_store_pkg::*;
#(
  parameter int WIDTH = DATA_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrlStrobes_t        strobes,
  input  logic [WIDTH-1:0]    keyCode,
  input  logic [WIDTH-1:0]    retLines,
  input  logic [ROW_BITS-1:0] scanRow,
  output logic [WIDTH-1:0]    rdData,
  output logic                rowChanged
);

  localparam int ROWS = 1 << ROW_BITS;

  logic [WIDTH-1:0] rowMem [ROWS];
  logic [WIDTH-1:0] wrData;

  assign wrData = strobes.selRet ? retLines : keyCode;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rowMem[r] <= '0;
      end else if (strobes.memWe && (strobes.wrRow == ROW_BITS'(r))) begin
        rowMem[r] <= wrData;
      end
    end
  end

  assign rdData     = rowMem[strobes.rdRow];
  assign rowChanged = (rowMem[scanRow] != retLines);

endmodule

// File: rtl/key_store_ctrl.sv
module key_store_ctrl
  import key_store_pkg::*;
#(
  parameter int DEPTH = 1 << ROW_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  storeMode_t          mode,
  input  logic                keyValid,
  input  logic                strobeN,
  input  logic                rowValid,
  input  logic [ROW_BITS-1:0] scanRow,
  input  logic                rdEn,
  input  logic [ROW_BITS-1:0] rdAddr,
  input  logic                errSet,
  input  logic                clrStatus,
  input  logic                clrSensorIrq,
  input  logic                rowChanged,
  output ctrlStrobes_t        strobes,
  output logic [ROW_BITS:0]   count,
  output logic                full,
  output logic                overrun,
  output logic                errFlag,
  output logic                irq
);

  localparam int CNT_W = ROW_BITS + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  storeMode_t          modeQ;
  logic                strobeQ;
  logic [ROW_BITS-1:0] wrPtr;
  logic [ROW_BITS-1:0] rdPtr;

  logic modeChg, isSensor, isStrobe, strobeFall;
  logic pushReq, pushOk, popOk, dropped, sensorWr;

  always_comb begin
    modeChg    = (mode != modeQ);
    isSensor   = (mode == MODE_SENSOR);
    isStrobe   = (mode == MODE_STROBE);
    strobeFall = strobeQ && !strobeN;
    pushReq    = !isSensor && (isStrobe ? strobeFall : keyValid);
    popOk      = !isSensor && !modeChg && rdEn && (count != '0);
    pushOk     = pushReq && !modeChg && !errFlag && ((count < DEPTH_C) || popOk);
    dropped    = pushReq && !modeChg && !errFlag && !pushOk;
    sensorWr   = isSensor && !modeChg && rowValid;

    strobes.memWe  = pushOk || sensorWr;
    strobes.wrRow  = isSensor ? scanRow : wrPtr;
    strobes.selRet = isSensor || isStrobe;
    strobes.rdRow  = isSensor ? rdAddr : rdPtr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeQ   <= MODE_KEYS;
      strobeQ <= 1'b1;
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      overrun <= 1'b0;
      errFlag <= 1'b0;
      irq     <= 1'b0;
    end else begin
      modeQ   <= mode;
      strobeQ <= strobeN;
      if (modeChg) begin
        wrPtr   <= '0;
        rdPtr   <= '0;
        count   <= '0;
        overrun <= 1'b0;
        errFlag <= 1'b0;
        irq     <= 1'b0;
      end else begin
        if (pushOk) wrPtr <= wrPtr + ROW_BITS'(1);
        if (popOk)  rdPtr <= rdPtr + ROW_BITS'(1);
        count <= count + CNT_W'(pushOk) - CNT_W'(popOk);

        if (dropped)        overrun <= 1'b1;
        else if (clrStatus) overrun <= 1'b0;

        if (errSet)         errFlag <= 1'b1;
        else if (clrStatus) errFlag <= 1'b0;

        if (isSensor) begin
          if (sensorWr && rowChanged) irq <= 1'b1;
          else if (clrSensorIrq)      irq <= 1'b0;
        end else begin
          irq <= popOk ? 1'b0 : (count != '0);
        end
      end
    end
  end

  assign full = (count == DEPTH_C);

endmodule

// File: rtl/key_store_top.sv
module key_store_top
  import key_store_pkg::*;
#(
  parameter int WIDTH = DATA_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode,
  input  logic                keyValid,
  input  logic [WIDTH-1:0]    keyCode,
  input  logic                strobeN,
  input  logic [WIDTH-1:0]    retLines,
  input  logic                rowValid,
  input  logic [ROW_BITS-1:0] scanRow,
  input  logic                rdEn,
  input  logic [ROW_BITS-1:0] rdAddr,
  input  logic                errSet,
  input  logic                clrStatus,
  input  logic                clrSensorIrq,
  output logic [WIDTH-1:0]    rdData,
  output logic [ROW_BITS:0]   count,
  output logic                full,
  output logic                overrun,
  output logic                errFlag,
  output logic                irq
);

  localparam int DEPTH = 1 << ROW_BITS;

  ctrlStrobes_t strobes;
  logic         rowChanged;
  storeMode_t   modeSel;

  assign modeSel = storeMode_t'(mode);

  key_store_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(modeSel), .keyValid(keyValid),
    .strobeN(strobeN), .rowValid(rowValid), .scanRow(scanRow),
    .rdEn(rdEn), .rdAddr(rdAddr), .errSet(errSet), .clrStatus(clrStatus),
    .clrSensorIrq(clrSensorIrq), .rowChanged(rowChanged), .strobes(strobes),
    .count(count), .full(full), .overrun(overrun), .errFlag(errFlag), .irq(irq)
  );

  key_store_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .keyCode(keyCode),
    .retLines(retLines), .scanRow(scanRow), .rdData(rdData),
    .rowChanged(rowChanged)
  );

endmodule

// File: rtl/key_store_checker.sv
module key_store_checker
  import key_store_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          mode,
  input logic                keyValid,
  input logic                rdEn,
  input logic                clrStatus,
  input logic                clrSensorIrq,
  input logic [ROW_BITS:0]   count,
  input logic                full,
  input logic                overrun,
  input logic                errFlag,
  input logic                irq
);

  localparam logic [ROW_BITS:0] CAP = (ROW_BITS + 1)'(1 << ROW_BITS);

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP);

  a_r3_drop_sets_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && $past(mode) == 2'd0 && keyValid && full && !rdEn && !errFlag)
    |=> (overrun && count == CAP));

  a_r3_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clrStatus && mode == $past(mode)) |=> overrun);

  a_r4_irq_drops_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd2 && mode == $past(mode) && rdEn && count != '0) |=> !irq);

  a_r4_irq_tracks_entries: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd2 && mode == $past(mode) && !rdEn && count != '0) |=> irq);

  a_r7_sensor_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && $past(mode) == 2'd2 && irq && !clrSensorIrq) |=> irq);

  a_r8_error_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd2 && mode == $past(mode) && errFlag && !rdEn) |=> $stable(count));

  a_r10_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |=> (count == '0 && !irq && !overrun && !errFlag));

endmodule

bind key_store_top key_store_checker u_checker (
  .clk(clk), .rst_n(rst_n), .mode(mode), .keyValid(keyValid), .rdEn(rdEn),
  .clrStatus(clrStatus), .clrSensorIrq(clrSensorIrq), .count(count),
  .full(full), .overrun(overrun), .errFlag(errFlag), .irq(irq)
);

// File: tb/tb_key_store_top.sv
`timescale 1ns/1ps
module tb_key_store_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       keyValid = 1'b0;
  logic [7:0] keyCode = 8'h00;
  logic       strobeN = 1'b1;
  logic [7:0] retLines = 8'h00;
  logic       rowValid = 1'b0;
  logic [2:0] scanRow = 3'd0;
  logic       rdEn = 1'b0;
  logic [2:0] rdAddr = 3'd0;
  logic       errSet = 1'b0;
  logic       clrStatus = 1'b0;
  logic       clrSensorIrq = 1'b0;
  logic [7:0] rdData;
  logic [3:0] count;
  logic       full, overrun, errFlag, irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  key_store_top dut (.*);

  // {keyValid, keyCode, rdEn, expected count, expected head}
  localparam logic [21:0] VECS [0:14] = '{
    {1'b1, 8'h11, 1'b0, 4'd1, 8'h11},
    {1'b1, 8'h22, 1'b0, 4'd2, 8'h11},
    {1'b1, 8'h33, 1'b1, 4'd2, 8'h22},
    {1'b0, 8'h00, 1'b1, 4'd1, 8'h33},
    {1'b0, 8'h00, 1'b1, 4'd0, 8'h00},
    {1'b0, 8'h00, 1'b1, 4'd0, 8'h00},
    {1'b1, 8'h40, 1'b0, 4'd1, 8'h40},
    {1'b1, 8'h41, 1'b0, 4'd2, 8'h40},
    {1'b1, 8'h42, 1'b0, 4'd3, 8'h40},
    {1'b1, 8'h43, 1'b0, 4'd4, 8'h40},
    {1'b1, 8'h44, 1'b0, 4'd5, 8'h40},
    {1'b1, 8'h45, 1'b0, 4'd6, 8'h40},
    {1'b1, 8'h46, 1'b0, 4'd7, 8'h40},
    {1'b1, 8'h47, 1'b0, 4'd8, 8'h40},
    {1'b1, 8'h99, 1'b0, 4'd8, 8'h40}
  };

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic quiet();
    keyValid = 0; rdEn = 0; rowValid = 0; errSet = 0;
    clrStatus = 0; clrSensorIrq = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 full", full, 0);
    check("R1 overrun", overrun, 0);
    check("R1 errFlag", errFlag, 0);
    check("R1 irq", irq, 0);
    check("R1 head", rdData, 8'h00);

    // R2 / R11 / R3: vector walk in key mode
    for (int v = 0; v < 15; v++) begin
      keyValid = VECS[v][21];
      keyCode  = VECS[v][20:13];
      rdEn     = VECS[v][12];
      tick(1);
      quiet();
      check($sformatf("R2 count step %0d", v), count, VECS[v][11:8]);
      if (VECS[v][11:8] != 0)
        check($sformatf("R2 head step %0d", v), rdData, VECS[v][7:0]);
    end
    check("R9 full at 8", full, 1);
    check("R3 overrun after ninth push", overrun, 1);
    for (int i = 0; i < 8; i++) begin
      check($sformatf("R2 drain order %0d", i), rdData, 8'h40 + i);
      rdEn = 1; tick(1); rdEn = 0;
    end
    check("R2 drained count", count, 0);
    check("R9 full after drain", full, 0);
    tick(2);
    check("R3 overrun sticky", overrun, 1);
    clrStatus = 1; tick(1); clrStatus = 0;
    check("R3 overrun cleared", overrun, 0);

    // R4 interrupt timing
    tick(1);
    check("R11 irq idle empty", irq, 0);
    keyValid = 1; keyCode = 8'hA1; tick(1);
    keyCode = 8'hA2; tick(1); keyValid = 0;
    check("R4 irq one cycle after first entry", irq, 1);
    rdEn = 1; tick(1); rdEn = 0;
    check("R4 irq low after read", irq, 0);
    tick(1);
    check("R4 irq back with entry left", irq, 1);
    rdEn = 1; tick(1); rdEn = 0;
    check("R4 irq low after last read", irq, 0);
    tick(1);
    check("R4 irq stays low when empty", irq, 0);

    // R10 mode change empties queue
    keyValid = 1; keyCode = 8'h5C; tick(1); keyValid = 0;
    errSet = 1; tick(1); errSet = 0;
    mode = 2'd1; tick(1);
    check("R10 count cleared", count, 0);
    check("R10 irq cleared", irq, 0);
    check("R10 errFlag cleared", errFlag, 0);

    // R5 strobed input
    retLines = 8'h5A; strobeN = 0; tick(3);
    check("R5 one push per low strobe", count, 1);
    check("R5 head", rdData, 8'h5A);
    strobeN = 1; tick(1);
    retLines = 8'hA5; strobeN = 0; tick(1); strobeN = 1;
    check("R5 second strobe", count, 2);
    keyValid = 1; tick(1); keyValid = 0;
    check("R5 keyValid ignored", count, 2);

    // R8 error freeze
    mode = 2'd0; tick(1);
    errSet = 1; tick(1); errSet = 0;
    check("R8 errFlag set", errFlag, 1);
    keyValid = 1; keyCode = 8'h77; tick(1); keyValid = 0;
    check("R8 push ignored", count, 0);
    clrStatus = 1; tick(1); clrStatus = 0;
    check("R8 errFlag cleared", errFlag, 0);
    keyValid = 1; keyCode = 8'h78; tick(1); keyValid = 0;
    check("R8 push after clear", count, 1);
    check("R8 head after clear", rdData, 8'h78);

    // R6 / R7 sensor image
    mode = 2'd2; tick(1);
    check("R10 irq cleared into sensor", irq, 0);
    scanRow = 3'd3; retLines = 8'hC3; rowValid = 1; tick(1); rowValid = 0;
    check("R7 irq on change", irq, 1);
    rdAddr = 3'd3; rdEn = 1; tick(1);
    check("R6 row read", rdData, 8'hC3);
    tick(1); rdEn = 0;
    check("R6 read does not consume", rdData, 8'hC3);
    check("R7 irq sticky", irq, 1);
    clrSensorIrq = 1; tick(1); clrSensorIrq = 0;
    check("R7 irq cleared", irq, 0);
    rowValid = 1; tick(1); rowValid = 0;
    check("R7 equal data no irq", irq, 0);
    scanRow = 3'd6; retLines = 8'h0F; rowValid = 1; tick(1); rowValid = 0;
    rdAddr = 3'd6; tick(1);
    check("R6 second row", rdData, 8'h0F);
    rdAddr = 3'd3;
    tick(1);
    check("R6 first row kept", rdData, 8'hC3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule